// File: doc/BRIEF.md
# Two-Input Edge-Qualified Count Decoder

This block sits in front of a timer's counter register and converts activity on its inputs into single-cycle count-up and count-down requests. The inputs are three external pins (two clock lines A and B and a trigger line) and three internal strobes: an event strobe, and overflow and underflow strobes from a paired timer. All inputs are synchronous to the system clock. Each one is registered once. The three pins can each go through an optional digital noise filter. Edges are taken against the previous filtered sample.

A 32-bit condition mask enables each of thirteen counting conditions separately for the up direction (bits 0 to 12) and for the down direction (bits 16 to 28). Both halves use the same condition order. The eight conditions that pair the level of one clock line with an edge on the other allow quadrature position counting. The overflow and underflow conditions allow two units to be cascaded.

The output stage is a three-state machine: `OS_IDLE`, `OS_UP` and `OS_DOWN`. Every cycle it moves to `OS_UP` if only the up half fired, to `OS_DOWN` if only the down half fired, and otherwise to `OS_IDLE`. Each pin filter is a six-state machine: `FS_LOW`, `FS_RISE1`, `FS_RISE2`, `FS_HIGH`, `FS_FALL1`, `FS_FALL2`. On each filter tick, a sample that differs from the settled level steps the filter `FS_LOW→FS_RISE1→FS_RISE2→FS_HIGH` (or `FS_HIGH→FS_FALL1→FS_FALL2→FS_LOW`). A sample equal to the settled level returns the filter from either intermediate state to the settled state (`FS_RISE1/FS_RISE2→FS_LOW`, `FS_FALL1/FS_FALL2→FS_HIGH`). Without a tick the filter holds its state.

Top module: `edge_count_decoder`

## Requirements
- R1: While reset is asserted, `cnt_up` and `cnt_dn` are 0 and `int_clk_sel` is 1.
- R2: Condition indices 0 to 7 are: A low & B rising, A low & B falling, A high & B rising, A high & B falling, B low & A rising, B low & A falling, B high & A rising, B high & A falling. With the filter off, a pin change driven before clock edge k produces its pulse after edge k+1. Conditions that are not enabled produce no pulse.
- R3: Condition 8 is a trigger rising edge and condition 9 is a trigger falling edge.
- R4: Condition 10 is the event strobe, condition 11 is a paired overflow and condition 12 is a paired underflow. Each strobe is registered once, so it has the same two-edge latency as the pins.
- R5: Mask bit 16+i enables condition i for `cnt_dn`. Mask bit i enables condition i for `cnt_up`.
- R6: If an enabled up condition and an enabled down condition fire in the same cycle, neither output pulses. `cnt_up` and `cnt_dn` are never high together.
- R7: When the whole mask is zero, `int_clk_sel` is 1 (one cycle after the mask changes) and no pulse is issued. A nonzero mask drives it to 0.
- R8: One input edge produces exactly one single-cycle pulse. A held level produces no further pulses.
- R9: `filt_en` bit 0/1/2 enables the filter on A/B/trigger. A filtered pin takes a new level only after three identical samples on consecutive filter ticks. With divider code 0, a change driven before edge k pulses after edge k+4, and a two-cycle glitch is rejected.
- R10: `filt_div` code n sets the filter tick to one in every 4^n system clock cycles (1, 4, 16, 64). With code 1, a held change pulses 11 to 14 edges after it is driven, and a seven-cycle glitch is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | External clock line A |
| pin_b | input | 1 | External clock line B |
| pin_trig | input | 1 | External trigger line |
| evt_stb | input | 1 | Internal event strobe |
| pair_ovf | input | 1 | Overflow strobe from the paired timer |
| pair_unf | input | 1 | Underflow strobe from the paired timer |
| cond_mask | input | 32 | Up enables in bits 0–12, down enables in bits 16–28 |
| filt_en | input | 3 | Filter enable for A, B and trigger |
| filt_div | input | 2 | Filter tick divider code (4^code) |
| cnt_up | output | 1 | Single-cycle count-up request |
| cnt_dn | output | 1 | Single-cycle count-down request |
| int_clk_sel | output | 1 | High when no condition is enabled (internal clock in use) |

## Verification
The bench uses the default parameters: thirteen conditions, a 32-bit mask with the down half at bit 16, and a filter divider that steps by four across four codes. With these values, every quadrature pairing and every strobe can be driven at an exact, known latency. The tick-every-cycle divider code gives cycle-exact filter checks, including a glitch one sample too short. The divide-by-four code is checked inside a bounded window, because the tick phase is free-running.

// File: rtl/cntdec_pkg.sv
`timescale 1ns/1ps
package cntdec_pkg;
    localparam int unsigned NCOND = 13;
    localparam int unsigned NPINS = 3;
    localparam int unsigned PIN_A = 0;
    localparam int unsigned PIN_B = 1;
    localparam int unsigned PIN_T = 2;

    typedef enum logic [2:0] {
        FS_LOW, FS_RISE1, FS_RISE2, FS_HIGH, FS_FALL1, FS_FALL2
    } filt_state_e;

    typedef enum logic [1:0] {
        OS_IDLE, OS_UP, OS_DOWN
    } out_state_e;
endpackage

// File: rtl/cntdec_tick.sv
`timescale 1ns/1ps
module cntdec_tick #(
    parameter int STEP_LOG2 = 2,
    parameter int NCODES    = 4,
    localparam int CODE_W   = $clog2(NCODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_sel,
    output logic              tick
);
    localparam int MAX_DIV = 1 << (STEP_LOG2 * (NCODES - 1));
    localparam int CW      = $clog2(MAX_DIV) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;

    always_comb begin
        reload = '0;
        for (int i = 0; i < NCODES; i++) begin
            if (div_sel == CODE_W'(i))
                reload = CW'((64'd1 << (STEP_LOG2 * i)) - 64'd1);
        end
    end

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= reload;
        else           cnt_q <= cnt_q - 1'b1;
    end

    // R10: code 0 keeps ticking every cycle
    p_div1_every_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && div_sel == '0) |-> tick);
    // R10: any larger code spaces ticks apart
    p_div_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0) |=> !tick);
endmodule

// File: rtl/cntdec_filter.sv
`timescale 1ns/1ps
module cntdec_filter
    import cntdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic level
);
    filt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                FS_LOW:   state_d = raw ? FS_RISE1 : FS_LOW;
                FS_RISE1: state_d = raw ? FS_RISE2 : FS_LOW;
                FS_RISE2: state_d = raw ? FS_HIGH  : FS_LOW;
                FS_HIGH:  state_d = raw ? FS_HIGH  : FS_FALL1;
                FS_FALL1: state_d = raw ? FS_HIGH  : FS_FALL2;
                FS_FALL2: state_d = raw ? FS_HIGH  : FS_LOW;
                default:  state_d = FS_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FS_HIGH, FS_FALL1, FS_FALL2: level = 1'b1;
            default:                     level = 1'b0;
        endcase
    end

    // R9: a new high level is only taken on a tick that sampled high
    p_accept_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> $past(raw && tick));
    p_accept_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> $past(!raw && tick));
endmodule

// File: rtl/cntdec_sense.sv
`timescale 1ns/1ps
module cntdec_sense
    import cntdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NPINS-1:0] pins,
    input  logic [NPINS-1:0] filt_en,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic raw_q;
        logic flt;
        logic lvl_d;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q <= 1'b0;
                lvl_d <= 1'b0;
            end else begin
                raw_q <= pins[p];
                lvl_d <= lvl[p];
            end
        end

        cntdec_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (raw_q),
            .level (flt)
        );

        assign lvl[p]  = filt_en[p] ? flt : raw_q;
        assign rise[p] = lvl[p] & ~lvl_d;
        assign fall[p] = ~lvl[p] & lvl_d;

        // R8: a rising edge cannot repeat on the next cycle
        p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rise[p] |=> !rise[p]);
    end
endmodule

// File: rtl/cntdec_cond.sv
`timescale 1ns/1ps
module cntdec_cond
    import cntdec_pkg::*;
(
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic             evt,
    input  logic             ovf,
    input  logic             unf,
    output logic [NCOND-1:0] cond
);
    always_comb begin
        cond[0]  = ~lvl[PIN_A] & rise[PIN_B];
        cond[1]  = ~lvl[PIN_A] & fall[PIN_B];
        cond[2]  =  lvl[PIN_A] & rise[PIN_B];
        cond[3]  =  lvl[PIN_A] & fall[PIN_B];
        cond[4]  = ~lvl[PIN_B] & rise[PIN_A];
        cond[5]  = ~lvl[PIN_B] & fall[PIN_A];
        cond[6]  =  lvl[PIN_B] & rise[PIN_A];
        cond[7]  =  lvl[PIN_B] & fall[PIN_A];
        cond[8]  = rise[PIN_T];
        cond[9]  = fall[PIN_T];
        cond[10] = evt;
        cond[11] = ovf;
        cond[12] = unf;
    end
endmodule

// File: rtl/edge_count_decoder.sv
`timescale 1ns/1ps
module edge_count_decoder
    import cntdec_pkg::*;
#(
    parameter int MASK_W    = 32,
    parameter int DN_BASE   = 16,
    parameter int STEP_LOG2 = 2,
    parameter int NCODES    = 4,
    localparam int DIV_W    = $clog2(NCODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_trig,
    input  logic              evt_stb,
    input  logic              pair_ovf,
    input  logic              pair_unf,
    input  logic [MASK_W-1:0] cond_mask,
    input  logic [NPINS-1:0]  filt_en,
    input  logic [DIV_W-1:0]  filt_div,
    output logic              cnt_up,
    output logic              cnt_dn,
    output logic              int_clk_sel
);
    logic             tick;
    logic [NPINS-1:0] lvl, rise, fall;
    logic [NCOND-1:0] cond;
    logic             evt_q, ovf_q, unf_q;
    logic             up_hit, dn_hit;
    out_state_e       os_q, os_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            evt_q <= evt_stb;
            ovf_q <= pair_ovf;
            unf_q <= pair_unf;
        end
    end

    cntdec_tick #(.STEP_LOG2(STEP_LOG2), .NCODES(NCODES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (filt_div),
        .tick    (tick)
    );

    cntdec_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pins    ({pin_trig, pin_b, pin_a}),
        .filt_en (filt_en),
        .lvl     (lvl),
        .rise    (rise),
        .fall    (fall)
    );

    cntdec_cond u_cond (
        .lvl  (lvl),
        .rise (rise),
        .fall (fall),
        .evt  (evt_q),
        .ovf  (ovf_q),
        .unf  (unf_q),
        .cond (cond)
    );

    assign up_hit = |(cond & cond_mask[NCOND-1:0]);
    assign dn_hit = |(cond & cond_mask[DN_BASE +: NCOND]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_q        <= OS_IDLE;
            int_clk_sel <= 1'b1;
        end else begin
            os_q        <= os_d;
            int_clk_sel <= (cond_mask == '0);
        end
    end

    always_comb begin
        unique case ({up_hit, dn_hit})
            2'b10:   os_d = OS_UP;
            2'b01:   os_d = OS_DOWN;
            default: os_d = OS_IDLE;
        endcase
    end

    always_comb begin
        cnt_up = 1'b0;
        cnt_dn = 1'b0;
        unique case (os_q)
            OS_UP:   cnt_up = 1'b1;
            OS_DOWN: cnt_dn = 1'b1;
            default: ;
        endcase
    end

    // R6: never both directions at once
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));
    // R7: an empty mask issues nothing
    p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_clk_sel |-> (!cnt_up && !cnt_dn));
    // R2: the four B-edge pairings are mutually exclusive
    p_b_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond[3:0]));
    // R4: a strobe pulse reaches the output state one edge later
    p_evt_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && cond_mask[10] && (cond & cond_mask[DN_BASE +: NCOND]) == '0) |=> cnt_up);
endmodule

// File: tb/edge_count_decoder_test.sv
`timescale 1ns/1ps
module edge_count_decoder_test;
    typedef struct {
        int    lo;
        int    hi;
        bit    up;
        bit    dn;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_a = 0, pin_b = 0, pin_trig = 0;
    logic        evt_stb = 0, pair_ovf = 0, pair_unf = 0;
    logic [31:0] cond_mask = '0;
    logic [2:0]  filt_en = '0;
    logic [1:0]  filt_div = '0;
    logic        cnt_up, cnt_dn, int_clk_sel;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 0;
    exp_t q[$];

    localparam logic [31:0] M1 = (32'd1 << 0) | (32'd1 << 3) | (32'd1 << 6) | (32'd1 << 8)
                               | (32'd1 << 10) | (32'd1 << 11)
                               | (32'd1 << 17) | (32'd1 << 18) | (32'd1 << 23)
                               | (32'd1 << 25) | (32'd1 << 28);
    localparam logic [31:0] M2 = M1 | (32'd1 << 4) | (32'd1 << 21);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edge_count_decoder uut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_trig(pin_trig),
        .evt_stb(evt_stb), .pair_ovf(pair_ovf), .pair_unf(pair_unf),
        .cond_mask(cond_mask), .filt_en(filt_en), .filt_div(filt_div),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .int_clk_sel(int_clk_sel)
    );

    task automatic push(input int lo, input int hi, input bit up, input bit dn, input string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.up = up; e.dn = dn; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic direct(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit got;
            bit handled;
            got = cnt_up | cnt_dn;
            handled = 0;
            if (q.size() > 0 && cyc >= q[0].lo && cyc <= q[0].hi) begin
                if (q[0].up | q[0].dn) begin
                    if (got) begin
                        checks++;
                        if (cnt_up !== q[0].up || cnt_dn !== q[0].dn) begin
                            errors++;
                            $display("FAIL %s got up/dn=%b%b exp=%b%b", q[0].tag, cnt_up, cnt_dn, q[0].up, q[0].dn);
                        end
                        void'(q.pop_front());
                        handled = 1;
                    end
                end else if (got) begin
                    checks++; errors++;
                    $display("FAIL %s got up/dn=%b%b exp=00", q[0].tag, cnt_up, cnt_dn);
                    void'(q.pop_front());
                    handled = 1;
                end
            end
            if (!handled && got) begin
                checks++; errors++;
                $display("FAIL R8 unexpected pulse got up/dn=%b%b exp=00 at cycle %0d", cnt_up, cnt_dn, cyc);
            end
            if (!handled && q.size() > 0 && cyc >= q[0].hi) begin
                checks++;
                if (q[0].up | q[0].dn) begin
                    errors++;
                    $display("FAIL %s got up/dn=00 exp=%b%b", q[0].tag, q[0].up, q[0].dn);
                end
                void'(q.pop_front());
            end
        end
    end

    // one stimulus step with the unfiltered two-edge latency (or five with filter code 0)
    task automatic apply(input logic a, input logic b, input logic t,
                         input logic ev, input logic ov, input logic un,
                         input bit eu, input bit ed, input int lat, input string tag);
        int c;
        @(negedge clk);
        pin_a = a; pin_b = b; pin_trig = t;
        evt_stb = ev; pair_ovf = ov; pair_unf = un;
        c = cyc;
        if (eu | ed) begin
            push(c + lat, c + lat, eu, ed, tag);
            push(c + lat + 1, c + lat + 4, 0, 0, {tag, " single"});
        end else begin
            push(c + 1, c + lat + 4, 0, 0, tag);
        end
        @(negedge clk);
        evt_stb = 0; pair_ovf = 0; pair_unf = 0;
        repeat (lat + 4) @(negedge clk);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        direct("R1 cnt_up in reset", cnt_up, 1'b0);
        direct("R1 cnt_dn in reset", cnt_dn, 1'b0);
        direct("R1 int_clk_sel in reset", int_clk_sel, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        cond_mask = M1;
        repeat (2) @(negedge clk);
        direct("R7 nonzero mask int_clk_sel", int_clk_sel, 1'b0);

        // quadrature pairings, state a b = 0 0
        apply(0, 1, 0, 0, 0, 0, 1, 0, 2, "R2 AL BR up");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, "R5 AL BF down");
        apply(1, 0, 0, 0, 0, 0, 0, 0, 2, "R2 BL AR disabled");
        apply(1, 1, 0, 0, 0, 0, 0, 1, 2, "R5 AH BR down");
        apply(1, 0, 0, 0, 0, 0, 1, 0, 2, "R2 AH BF up");
        apply(0, 0, 0, 0, 0, 0, 0, 0, 2, "R2 BL AF disabled");
        apply(0, 1, 0, 0, 0, 0, 1, 0, 2, "R2 AL BR up again");
        apply(1, 1, 0, 0, 0, 0, 1, 0, 2, "R2 BH AR up");
        apply(0, 1, 0, 0, 0, 0, 0, 1, 2, "R5 BH AF down");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, "R5 AL BF down again");
        // trigger and strobes
        apply(0, 0, 1, 0, 0, 0, 1, 0, 2, "R3 trig rise up");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, "R3 trig fall down");
        apply(0, 0, 0, 1, 0, 0, 1, 0, 2, "R4 event up");
        apply(0, 0, 0, 0, 1, 0, 1, 0, 2, "R4 pair overflow up");
        apply(0, 0, 0, 0, 0, 1, 0, 1, 2, "R4 pair underflow down");

        // cancellation
        @(negedge clk); cond_mask = M1 | (32'd1 << 24);
        apply(0, 0, 1, 0, 0, 0, 0, 0, 2, "R6 trig rise both halves");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, "R6 trig fall down only");
        @(negedge clk); cond_mask = M1;
        apply(0, 0, 0, 1, 0, 1, 0, 0, 2, "R6 event with underflow");

        // empty mask
        @(negedge clk); cond_mask = '0;
        repeat (2) @(negedge clk);
        direct("R7 zero mask int_clk_sel", int_clk_sel, 1'b1);
        apply(0, 1, 0, 0, 0, 0, 0, 0, 2, "R7 zero mask B rise");
        apply(0, 0, 0, 1, 0, 1, 0, 0, 2, "R7 zero mask strobes");
        @(negedge clk); cond_mask = M2;
        repeat (2) @(negedge clk);
        direct("R7 restored mask int_clk_sel", int_clk_sel, 1'b0);

        // filter on A, code 0
        @(negedge clk); filt_en = 3'b001; filt_div = 2'd0;
        repeat (4) @(negedge clk);
        apply(1, 0, 0, 0, 0, 0, 1, 0, 5, "R9 filtered A rise up");
        @(negedge clk);
        pin_a = 0; c = cyc;
        push(c + 1, c + 14, 0, 0, "R9 two-cycle glitch rejected");
        repeat (2) @(negedge clk);
        pin_a = 1;
        repeat (16) @(negedge clk);
        apply(0, 0, 0, 0, 0, 0, 0, 1, 5, "R9 filtered A fall down");

        // filter code 1
        @(negedge clk); filt_div = 2'd1;
        repeat (8) @(negedge clk);
        @(negedge clk);
        pin_a = 1; c = cyc;
        push(c + 11, c + 14, 1, 0, "R10 div4 A rise up");
        push(c + 15, c + 19, 0, 0, "R10 div4 single");
        repeat (22) @(negedge clk);
        @(negedge clk);
        pin_a = 0; c = cyc;
        push(c + 1, c + 30, 0, 0, "R10 div4 seven-cycle glitch rejected");
        repeat (7) @(negedge clk);
        pin_a = 1;
        repeat (32) @(negedge clk);
        @(negedge clk);
        pin_a = 0; c = cyc;
        push(c + 11, c + 14, 0, 1, "R10 div4 A fall down");
        repeat (22) @(negedge clk);

        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R8 leftover expectations got=%0d exp=0", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog (all) got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule